// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block sits next to a single-port synchronous SRAM and runs the March C- test on it at the functional clock rate. A one-cycle start pulse, for example from the power-on sequence, launches the test. The controller then drives the memory's address, read-enable, write-enable and write-data pins and issues exactly one memory operation per clock until the algorithm ends.

The test has six elements, always run in the same order. Element 0 writes zeros everywhere. Elements 1 and 2 run upward, and elements 3 and 4 run downward. Each of these four reads the background it expects at an address and then writes the opposite background there. Element 5 reads zeros everywhere. Because the address order reverses between elements, coupling faults are caught whether the aggressor cell sits below or above its victim. Transition faults in either direction fail one of the read-then-write pairs.

The SRAM returns read data one cycle after the read. The controller carries the expected background and a compare-valid flag along with that latency, and it records any mismatch in a sticky fail flag. At the end it shows idle, done, and pass or fail on three status outputs.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, busy, done and fail are all 0, and both the read enable and the write enable stay 0.
- R2: A start pulse sampled while busy is 0 raises busy at the next clock edge. Busy then stays high for exactly 10N+1 cycles for an N-word memory. The first 10N of those cycles each carry exactly one read or one write. The final cycle carries no access, and done rises at the edge that ends it.
- R3: The operations run in this order. E0 writes 0, ascending. E1 reads 0 then writes 1 at each address, ascending. E2 reads 1 then writes 0, ascending. E3 reads 0 then writes 1, descending. E4 reads 1 then writes 0, descending. E5 reads 0, ascending. Ascending runs from address 0 to N-1, and descending runs from N-1 to 0.
- R4: A "0" write puts all zeros on the full write-data word, and a "1" write puts all ones on it.
- R5: Read data is sampled one cycle after a read is issued. It is compared with the full-width background that read expects. On a fault-free memory the test ends with fail at 0.
- R6: A bit stuck at 1 in any word makes the test end with fail at 1.
- R7: A cell that cannot switch 0 to 1, or one that cannot switch 1 to 0, makes the test end with fail at 1.
- R8: A coupling fault, in which writing a 1 to an aggressor word flips a bit in a victim word, makes the test end with fail at 1. This holds with the victim above the aggressor and with the victim below it.
- R9: Fail is set by the first mismatch and stays set while the block idles. Fail and done both stay at their final values until a start is accepted, which clears them at the next edge.
- R10: A start pulse that arrives while busy is 1 has no effect. The operation sequence and the busy length are the same as in an undisturbed run.
- R11: The depth need not be a power of two. No access ever uses an address of N or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; honoured only while idle |
| mem_addr_o | output | AW | SRAM word address |
| mem_re_o | output | 1 | SRAM read enable |
| mem_we_o | output | 1 | SRAM write enable |
| mem_wdata_o | output | WIDTH | SRAM write data |
| mem_rdata_i | input | WIDTH | SRAM read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished; held until the next start |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The embedded assertions check the behaviour that holds on every cycle. Each cycle carries at most one access, and every address stays below the depth. The address moves by exactly one per step in the direction of the current element, and elements only ever advance by one. A registered mismatch always sets fail, and fail stays set without a restart. Done never coexists with busy, and done rises only after the final drain cycle. Properties cannot show whether a memory defect is actually found, or that the whole operation trace and its length are correct. The bench's scenarios show these. They compare every access against a trace built independently and count the busy cycles. They also inject stuck-at, transition and upward or downward coupling faults into the behavioural SRAM and check the final verdict.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_e;

    // One memory operation of a march element: read or write, and background bit.
    typedef struct packed {
        logic is_rd;
        logic bg;
    } march_op_t;

    // A march element: traversal direction, operation count, and its operations.
    typedef struct packed {
        logic      down;
        logic      two_ops;
        march_op_t op0;
        march_op_t op1;
    } march_elem_t;

    // Command presented to the memory in one cycle.
    typedef struct packed {
        logic we;
        logic re;
        logic bg;
    } mem_cmd_t;

    localparam int unsigned NUM_ELEMS = 6;
    localparam logic [2:0]  LAST_ELEM = 3'(NUM_ELEMS - 1);

    function automatic march_elem_t elem_desc(input logic [2:0] idx);
        march_elem_t d;
        case (idx)
            3'd0:    d = '{down: 1'b0, two_ops: 1'b0, op0: '{1'b0, 1'b0}, op1: '{1'b0, 1'b0}};
            3'd1:    d = '{down: 1'b0, two_ops: 1'b1, op0: '{1'b1, 1'b0}, op1: '{1'b0, 1'b1}};
            3'd2:    d = '{down: 1'b0, two_ops: 1'b1, op0: '{1'b1, 1'b1}, op1: '{1'b0, 1'b0}};
            3'd3:    d = '{down: 1'b1, two_ops: 1'b1, op0: '{1'b1, 1'b0}, op1: '{1'b0, 1'b1}};
            3'd4:    d = '{down: 1'b1, two_ops: 1'b1, op0: '{1'b1, 1'b1}, op1: '{1'b0, 1'b0}};
            default: d = '{down: 1'b0, two_ops: 1'b0, op0: '{1'b1, 1'b0}, op1: '{1'b0, 1'b0}};
        endcase
        return d;
    endfunction

    function automatic logic [2:0] next_elem(input logic [2:0] idx);
        return 3'(idx + 3'd1);
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;
    logic          down_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            addr_q <= load_down ? TOP_ADDR : '0;
            down_q <= load_down;
        end else if (step) begin
            addr_q <= down_q ? AW'(addr_q - 1'b1) : AW'(addr_q + 1'b1);
        end
    end

    assign addr_o = addr_q;
    assign last_o = down_q ? (addr_q == '0) : (addr_q == TOP_ADDR);

    // R11: address never leaves the memory
    p_addr_in_range_r11: assert property (@(posedge clk) disable iff (rst)
        {1'b0, addr_q} < (AW+1)'(DEPTH))
        else $error("address out of range");

    // R3: each step moves one word in the current direction
    p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr_q == ($past(down_q) ? AW'($past(addr_q) - 1'b1)
                                                      : AW'($past(addr_q) + 1'b1))))
        else $error("address step wrong");

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          launch_o,
    output logic          busy_o,
    output logic          flush_o,
    output mem_cmd_t      cmd_o,
    output logic [AW-1:0] addr_o
);
    seq_state_e  state_q;
    logic [2:0]  elem_q;
    logic        op_q;
    march_elem_t desc;
    march_op_t   cur_op;
    logic        run;
    logic        addr_done;
    logic        ag_last;
    logic        ag_load;
    logic        ag_load_down;
    logic        ag_step;

    assign desc      = elem_desc(elem_q);
    assign cur_op    = op_q ? desc.op1 : desc.op0;
    assign run       = (state_q == ST_RUN);
    assign launch_o  = (state_q == ST_IDLE) && start_i;
    assign addr_done = !desc.two_ops || op_q;

    assign ag_load      = launch_o || (run && addr_done && ag_last && elem_q != LAST_ELEM);
    assign ag_load_down = launch_o ? 1'b0 : elem_desc(next_elem(elem_q)).down;
    assign ag_step      = run && addr_done && !ag_last;

    mbist_addr_gen #(.DEPTH(DEPTH)) i_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .addr_o    (addr_o),
        .last_o    (ag_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            op_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        elem_q  <= '0;
                        op_q    <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (!addr_done) begin
                        op_q <= 1'b1;
                    end else begin
                        op_q <= 1'b0;
                        if (ag_last) begin
                            if (elem_q == LAST_ELEM) state_q <= ST_FLUSH;
                            else                     elem_q  <= next_elem(elem_q);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o    = '0;
        if (run) begin
            cmd_o.re = cur_op.is_rd;
            cmd_o.we = !cur_op.is_rd;
            cmd_o.bg = cur_op.bg;
        end
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign flush_o = (state_q == ST_FLUSH);

    // R2: never read and write in the same cycle
    p_single_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_o.we && cmd_o.re))
        else $error("read and write together");

    // R3: elements only advance one at a time during a run
    p_elem_order_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && elem_q != $past(elem_q)) |-> (elem_q == next_elem($past(elem_q))))
        else $error("element skipped");

    // R10: a start during a run does not rewind the element
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (run && start_i) |=> (elem_q >= $past(elem_q)))
        else $error("start restarted a busy run");

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rd_issue,
    input  logic             rd_bg,
    input  logic [WIDTH-1:0] rdata,
    output logic             fail_o
);
    logic vld_q;
    logic exp_q;
    logic fail_q;
    logic mismatch;

    assign mismatch = vld_q && (rdata != {WIDTH{exp_q}});

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            exp_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            vld_q <= rd_issue;
            exp_q <= rd_bg;
            if (clr)           fail_q <= 1'b0;
            else if (mismatch) fail_q <= 1'b1;
        end
    end

    assign fail_o = fail_q;

    // R9: fail stays set until a new start clears it
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !clr) |=> fail_q)
        else $error("fail flag dropped");

    // R5: a mismatching returned word always raises fail
    p_mismatch_sets_fail_r5: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !clr && rdata != {WIDTH{exp_q}}) |=> fail_q)
        else $error("mismatch missed");

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_re_o,
    output logic             mem_we_o,
    output logic [WIDTH-1:0] mem_wdata_o,
    input  logic [WIDTH-1:0] mem_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    mem_cmd_t cmd;
    logic     launch;
    logic     flush;
    logic     done_q;

    mbist_seq #(.DEPTH(DEPTH)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .launch_o (launch),
        .busy_o   (busy_o),
        .flush_o  (flush),
        .cmd_o    (cmd),
        .addr_o   (mem_addr_o)
    );

    mbist_cmp #(.WIDTH(WIDTH)) i_cmp (
        .clk      (clk),
        .rst      (rst),
        .clr      (launch),
        .rd_issue (cmd.re),
        .rd_bg    (cmd.bg),
        .rdata    (mem_rdata_i),
        .fail_o   (fail_o)
    );

    always_ff @(posedge clk) begin
        if (rst)         done_q <= 1'b0;
        else if (launch) done_q <= 1'b0;
        else if (flush)  done_q <= 1'b1;
    end

    assign mem_re_o    = cmd.re;
    assign mem_we_o    = cmd.we;
    assign mem_wdata_o = {WIDTH{cmd.bg}};
    assign done_o      = done_q;

    // R1: memory untouched while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_re_o && !mem_we_o))
        else $error("access while idle");

    // R9: done and busy never overlap
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o)
        else $error("done while busy");

    // R2: done rises only after the drain cycle
    p_done_after_flush_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(flush))
        else $error("done without drain");

endmodule

// File: tb/test_mbist_ctrl.sv
module test_mbist_ctrl;
    localparam int N     = 12;
    localparam int W     = 8;
    localparam int AW    = $clog2(N);
    localparam int NOPS  = 10 * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic          busy, done, fail;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mbist_ctrl #(.DEPTH(N), .WIDTH(W)) i_mbist_ctrl (
        .clk(clk), .rst(rst), .start_i(start),
        .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    // ---------------- behavioural SRAM with fault injection ----------------
    // 0 none, 1 stuck-at-1, 2 no 0->1, 3 no 1->0, 4 coupling up, 5 coupling down
    int           fault_mode = 0;
    logic [W-1:0] mem [N];

    always @(posedge clk) begin
        if (mem_we) begin
            logic [W-1:0] nv;
            logic [W-1:0] ov;
            nv = mem_wdata;
            ov = mem[mem_addr];
            if (fault_mode == 1 && mem_addr == 5) nv[3] = 1'b1;
            if (fault_mode == 2 && mem_addr == 7 && !ov[1]) nv[1] = 1'b0;
            if (fault_mode == 3 && mem_addr == 2 && ov[0]) nv[0] = 1'b1;
            if (fault_mode == 4 && mem_addr == 3 && !ov[0] && nv[0]) mem[8][0] = ~mem[8][0];
            if (fault_mode == 5 && mem_addr == 9 && !ov[0] && nv[0]) mem[4][0] = ~mem[4][0];
            mem[mem_addr] = nv;
        end
        if (mem_re) begin
            logic [W-1:0] rv;
            rv = mem[mem_addr];
            if (fault_mode == 1 && mem_addr == 5) rv[3] = 1'b1;
            mem_rdata <= rv;
        end
    end

    // ---------------- expected operation trace (R3, R4) ----------------
    int e_we [NOPS];
    int e_addr [NOPS];
    int e_bg [NOPS];

    initial begin
        int k;
        int down [6] = '{0, 0, 0, 1, 1, 0};
        int nops [6] = '{1, 2, 2, 2, 2, 1};
        int w0   [6] = '{1, 0, 0, 0, 0, 0};
        int b0   [6] = '{0, 0, 1, 0, 1, 0};
        k = 0;
        for (int e = 0; e < 6; e++) begin
            for (int i = 0; i < N; i++) begin
                int a;
                a = down[e] ? (N - 1 - i) : i;
                e_we[k] = w0[e]; e_addr[k] = a; e_bg[k] = b0[e]; k++;
                if (nops[e] == 2) begin
                    e_we[k] = 1; e_addr[k] = a; e_bg[k] = 1 - b0[e]; k++;
                end
            end
        end
    end

    // ---------------- trace monitor ----------------
    int opn = 0;
    int trace_bad = 0;

    always @(negedge clk) begin
        if (busy) begin
            if (opn < NOPS) begin
                if (mem_we != e_we[opn][0] || mem_re != !e_we[opn][0] ||
                    int'(mem_addr) != e_addr[opn] ||
                    (mem_we && mem_wdata != {W{e_bg[opn][0]}}))
                    trace_bad++;
            end else if (mem_we || mem_re) begin
                trace_bad++;
            end
            opn++;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected <= 50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic init_mem(input logic [W-1:0] v);
        for (int i = 0; i < N; i++) mem[i] = v;
    endtask

    // Runs one complete test; optional stray start pulse at cycle poke (R10).
    task automatic run_march(input string req, input int mode, input int exp_fail, input int poke);
        int n;
        fault_mode = mode;
        @(negedge clk);
        opn = 0;
        trace_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: start clears done and fail, R2: busy rises
        check("R9", "fail cleared by start", int'(fail), 0);
        check("R9", "done cleared by start", int'(done), 0);
        check("R2", "busy after start", int'(busy), 1);
        n = 0;
        while (!done && n < 2000) begin
            if (n == poke) start = 1'b1;
            else           start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R2", "done reached", int'(done), 1);
        check("R2", "busy cycles 10N+1", opn, NOPS + 1);
        check("R3", "trace mismatches (R4 R11)", trace_bad, 0);
        check(req, "final fail", int'(fail), exp_fail);
    endtask

    task automatic test_reset();
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "fail in reset", int'(fail), 0);
        check("R1", "no access idle", int'(mem_we | mem_re), 0);
    endtask

    task automatic test_clean();
        init_mem('1);
        run_march("R5", 0, 0, -1);
    endtask

    task automatic test_stuck();
        init_mem('0);
        run_march("R6", 1, 1, -1);
        repeat (5) @(negedge clk);
        check("R9", "fail held after end", int'(fail), 1);
        check("R9", "done held after end", int'(done), 1);
    endtask

    task automatic test_transition();
        init_mem('0);
        run_march("R7", 2, 1, -1);
        init_mem('1);
        run_march("R7", 3, 1, -1);
    endtask

    task automatic test_coupling();
        init_mem('0);
        run_march("R8", 4, 1, -1);
        init_mem('0);
        run_march("R8", 5, 1, -1);
    endtask

    task automatic test_restart_pass();
        init_mem('0);
        run_march("R9", 0, 0, -1);
    endtask

    task automatic test_stray_start();
        init_mem('0);
        run_march("R10", 0, 0, 30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        test_reset();
        test_clean();
        test_stuck();
        test_restart_pass();
        test_transition();
        test_coupling();
        test_stray_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule